// File: doc/BRIEF.md
# Configuration Source Recovery Sequencer

This block decides what to do when the integrity check on a reprogrammable processing device fails. The device can be loaded from any of three memories that hold the same configuration image. The check alone cannot tell a corrupted image from a damaged device. The sequencer therefore reloads the device from another usable memory and waits for the next check result.

If the retry fails, the device is taken to be permanently damaged and the module enters a sticky bypass state. If the retry passes, the original memory is marked faulty, the device keeps running from the new memory, and a rewrite of the suspect memory is requested.

A completed rewrite clears the memory's flag. A memory whose rewrite fails twice is retired until reset. Every request that waits for an answer is covered by a watchdog, and a timeout counts as a failure.

Memories are numbered 0 to NUM_SRC-1. The sequencer chooses the next memory by rotation from the active one and skips memories that are flagged. It does not program memories and does not run checks itself.

Top module: `cfg_source_recovery`

## Requirements
- R1: After reset the sequencer is in this state: bypass and busy are low, no request is raised, activeSrc is 0, and every faulty and retired flag is clear.
- R2: A failing check result (checkValid=1, checkPass=0) in the idle state raises cfgReq on the next cycle. cfgSel is the first memory with a clear faulty flag, searching in the order activeSrc+1, activeSrc+2, … modulo NUM_SRC.
- R3: After cfgDone, the next check result decides the retry. A failing result enters bypass.
- R4: A passing retry result does three things. It sets the faulty flag of the memory that was active when the failure was seen. It makes the retry memory the active one. It raises refReq with refSel naming the suspect memory.
- R5: refDone with refOk=1 clears the faulty flag of the refreshed memory and returns the sequencer to idle.
- R6: A failed rewrite (refDone with refOk=0) drops refReq for exactly one cycle and then raises it again for the same memory. A second consecutive failure sets that memory's retired flag, and the memory stays flagged faulty and excluded until reset.
- R7: Bypass is sticky. Check results have no effect while it is set, and only bypassClr returns the sequencer to idle.
- R8: A configure or refresh request left unanswered for TIMEOUT_CYC cycles counts as a failure. An unanswered configure request enters bypass. An unanswered refresh request counts as a failed rewrite.
- R9: A check failure when no other memory is usable enters bypass directly, without a configure request.
- R10: A check failure seen during a rewrite is held. This includes a failure in the same cycle as refDone. Recovery starts as soon as the rewrite outcome has been applied.
- R11: Passing check results in idle, and any check result while a configure request is open, cause no request and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkValid | input | 1 | A check result is present this cycle |
| checkPass | input | 1 | Verdict of the check, 1 = pass |
| cfgDone | input | 1 | The device finished loading from cfgSel |
| refDone | input | 1 | The memory rewrite finished |
| refOk | input | 1 | Outcome of the rewrite, 1 = success |
| bypassClr | input | 1 | External command to leave bypass |
| cfgReq | output | 1 | Request to load the device from cfgSel, held until answered |
| cfgSel | output | $clog2(NUM_SRC) | Memory for the device load |
| refReq | output | 1 | Request to rewrite memory refSel, held until answered |
| refSel | output | $clog2(NUM_SRC) | Memory to be rewritten |
| bypass | output | 1 | The module is bypassed (device declared faulty) |
| busy | output | 1 | A recovery or rewrite is in progress |
| activeSrc | output | $clog2(NUM_SRC) | Memory the device currently runs from |
| srcFaulty | output | NUM_SRC | One faulty flag per memory |
| srcRetired | output | NUM_SRC | One retired flag per memory |

## Verification
The rewrite of a suspect memory and a new check failure can fall in the same cycle. The bench provokes this by raising refDone, refOk and a failing check result on one edge. It then expects the refreshed memory to be usable again, and the pending recovery to pick that memory, skipping a retired one. The scoreboard orders every request edge and bypass entry, so a lost or duplicated recovery shows up as a missing or surplus event.

// File: rtl/cfg_rec_pkg.sv
package cfg_rec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_CHK,
    ST_REF,
    ST_RGAP,
    ST_BYP
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startRec;  // capture suspect and retry target
    logic commit;    // retry passed: flag suspect, switch active
    logic refGood;   // rewrite succeeded
    logic refBad;    // rewrite failed or timed out
    logic setPend;   // remember a check failure seen during rewrite
    logic clrPend;   // pending failure consumed
    logic armTmr;    // restart watchdog
  } recStrobe_t;

endpackage

// File: rtl/cfg_rec_datapath.sv
module cfg_rec_datapath
  import cfg_rec_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter int REF_TRIES   = 2,
  localparam int SEL_W = $clog2(NUM_SRC),
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1),
  localparam int CNT_W = $clog2(REF_TRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  recStrobe_t         stb,
  output logic               hasSpare,
  output logic               tmo,
  output logic               refLast,
  output logic               pend,
  output logic [SEL_W-1:0]   activeSrc,
  output logic [SEL_W-1:0]   suspectSrc,
  output logic [SEL_W-1:0]   targetSrc,
  output logic [NUM_SRC-1:0] srcFaulty,
  output logic [NUM_SRC-1:0] srcRetired
);

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] failCnt [NUM_SRC];
  logic [SEL_W-1:0] spareIdx;

  // rotation search for the next usable memory after the active one
  always_comb begin
    hasSpare = 1'b0;
    spareIdx = '0;
    for (int k = 1; k < NUM_SRC; k++) begin
      int idx;
      idx = int'(activeSrc) + k;
      if (idx >= NUM_SRC) idx = idx - NUM_SRC;
      if (!hasSpare && !srcFaulty[idx]) begin
        hasSpare = 1'b1;
        spareIdx = SEL_W'(idx);
      end
    end
  end

  assign tmo     = (tmr == TMR_W'(TIMEOUT_CYC - 1));
  assign refLast = (failCnt[suspectSrc] == CNT_W'(REF_TRIES - 1));

  // watchdog timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.armTmr) begin
      tmr <= '0;
    end else if (tmr != TMR_W'(TIMEOUT_CYC)) begin
      tmr <= tmr + 1'b1;
    end
  end

  // source bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSrc  <= '0;
      suspectSrc <= '0;
      targetSrc  <= '0;
      pend       <= 1'b0;
    end else begin
      if (stb.startRec) begin
        suspectSrc <= activeSrc;
        targetSrc  <= spareIdx;
      end
      if (stb.commit) activeSrc <= targetSrc;
      if (stb.setPend) pend <= 1'b1;
      else if (stb.clrPend) pend <= 1'b0;
    end
  end

  // per-memory flags, one slice per memory
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic isSus;
    assign isSus = (suspectSrc == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcFaulty[g]  <= 1'b0;
        srcRetired[g] <= 1'b0;
        failCnt[g]    <= '0;
      end else if (isSus) begin
        if (stb.commit) srcFaulty[g] <= 1'b1;
        if (stb.refGood) begin
          srcFaulty[g] <= 1'b0;
          failCnt[g]   <= '0;
        end
        if (stb.refBad) begin
          if (refLast) srcRetired[g] <= 1'b1;
          else failCnt[g] <= failCnt[g] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfg_rec_ctrl.sv
module cfg_rec_ctrl
  import cfg_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       checkValid,
  input  logic       checkPass,
  input  logic       cfgDone,
  input  logic       refDone,
  input  logic       refOk,
  input  logic       bypassClr,
  input  logic       hasSpare,
  input  logic       tmo,
  input  logic       refLast,
  input  logic       pend,
  output recStrobe_t stb,
  output logic       cfgReq,
  output logic       refReq,
  output logic       bypass,
  output logic       busy
);

  recState_t st, stNext;
  logic checkFail;

  assign checkFail = checkValid && !checkPass;

  always_comb begin
    stNext = st;
    stb    = '0;
    unique case (st)
      ST_IDLE: begin
        if (checkFail || pend) begin
          stb.clrPend = 1'b1;
          if (hasSpare) begin
            stb.startRec = 1'b1;
            stNext = ST_CFG;
          end else begin
            stNext = ST_BYP;
          end
        end
      end
      ST_CFG: begin
        if (cfgDone) stNext = ST_CHK;
        else if (tmo) stNext = ST_BYP;
      end
      ST_CHK: begin
        if (checkValid) begin
          if (checkPass) begin
            stb.commit = 1'b1;
            stNext = ST_REF;
          end else begin
            stNext = ST_BYP;
          end
        end else if (tmo) begin
          stNext = ST_BYP;
        end
      end
      ST_REF: begin
        if (checkFail) stb.setPend = 1'b1;
        if (refDone && refOk) begin
          stb.refGood = 1'b1;
          stNext = ST_IDLE;
        end else if (refDone || tmo) begin
          stb.refBad = 1'b1;
          stNext = refLast ? ST_IDLE : ST_RGAP;
        end
      end
      ST_RGAP: begin
        if (checkFail) stb.setPend = 1'b1;
        stNext = ST_REF;
      end
      ST_BYP: begin
        stb.clrPend = 1'b1;
        if (bypassClr) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
    stb.armTmr = (stNext != st);
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else st <= stNext;
  end

  assign cfgReq = (st == ST_CFG);
  assign refReq = (st == ST_REF);
  assign bypass = (st == ST_BYP);
  assign busy   = (st != ST_IDLE) && (st != ST_BYP);

endmodule

// File: rtl/cfg_source_recovery.sv
module cfg_source_recovery
  import cfg_rec_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter int REF_TRIES   = 2,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               checkValid,
  input  logic               checkPass,
  input  logic               cfgDone,
  input  logic               refDone,
  input  logic               refOk,
  input  logic               bypassClr,
  output logic               cfgReq,
  output logic [SEL_W-1:0]   cfgSel,
  output logic               refReq,
  output logic [SEL_W-1:0]   refSel,
  output logic               bypass,
  output logic               busy,
  output logic [SEL_W-1:0]   activeSrc,
  output logic [NUM_SRC-1:0] srcFaulty,
  output logic [NUM_SRC-1:0] srcRetired
);

  recStrobe_t stb;
  logic hasSpare, tmo, refLast, pend;

  cfg_rec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .checkValid(checkValid), .checkPass(checkPass),
    .cfgDone(cfgDone), .refDone(refDone), .refOk(refOk),
    .bypassClr(bypassClr),
    .hasSpare(hasSpare), .tmo(tmo), .refLast(refLast), .pend(pend),
    .stb(stb),
    .cfgReq(cfgReq), .refReq(refReq), .bypass(bypass), .busy(busy)
  );

  cfg_rec_datapath #(
    .NUM_SRC(NUM_SRC), .TIMEOUT_CYC(TIMEOUT_CYC), .REF_TRIES(REF_TRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hasSpare(hasSpare), .tmo(tmo), .refLast(refLast), .pend(pend),
    .activeSrc(activeSrc), .suspectSrc(refSel), .targetSrc(cfgSel),
    .srcFaulty(srcFaulty), .srcRetired(srcRetired)
  );

endmodule

// File: rtl/cfg_rec_checker.sv
module cfg_rec_checker #(
  parameter int NUM_SRC     = 3,
  parameter int TIMEOUT_CYC = 64,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               checkValid,
  input logic               checkPass,
  input logic               cfgDone,
  input logic               refDone,
  input logic               refOk,
  input logic               bypassClr,
  input logic               cfgReq,
  input logic [SEL_W-1:0]   cfgSel,
  input logic               refReq,
  input logic [SEL_W-1:0]   refSel,
  input logic               bypass,
  input logic               busy,
  input logic [SEL_W-1:0]   activeSrc,
  input logic [NUM_SRC-1:0] srcFaulty,
  input logic [NUM_SRC-1:0] srcRetired
);

  logic [31:0] cfgAge, refAge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAge <= '0;
      refAge <= '0;
    end else begin
      cfgAge <= cfgReq ? cfgAge + 1 : '0;
      refAge <= refReq ? refAge + 1 : '0;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgReq && refReq) && !(bypass && (cfgReq || refReq))); // R7

  AST_RETRY_FROM_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (cfgSel != activeSrc) && !srcFaulty[cfgSel]); // R2

  AST_REFRESH_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> srcFaulty[refSel] && (refSel != activeSrc)); // R4

  AST_BYPASS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bypass && !bypassClr |=> bypass); // R7

  AST_CFG_WATCHDOG: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgAge < TIMEOUT_CYC); // R8

  AST_REF_WATCHDOG: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> refAge < TIMEOUT_CYC); // R8

  for (genvar g = 0; g < NUM_SRC; g++) begin : gChk
    AST_RETIRED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      srcRetired[g] |=> srcRetired[g] && srcFaulty[g]); // R6
  end

endmodule

bind cfg_source_recovery cfg_rec_checker #(
  .NUM_SRC(NUM_SRC), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (.*);

// File: tb/tb_cfg_source_recovery.sv
module tb_cfg_source_recovery;

  localparam int NS  = 3;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic checkValid = 0, checkPass = 0, cfgDone = 0, refDone = 0, refOk = 0, bypassClr = 0;
  logic cfgReq, refReq, bypass, busy;
  logic [1:0] cfgSel, refSel, activeSrc;
  logic [NS-1:0] srcFaulty, srcRetired;

  always #10 clk = ~clk;  // 50 MHz

  cfg_source_recovery #(.NUM_SRC(NS), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .checkPass(checkPass),
    .cfgDone(cfgDone), .refDone(refDone), .refOk(refOk), .bypassClr(bypassClr),
    .cfgReq(cfgReq), .cfgSel(cfgSel), .refReq(refReq), .refSel(refSel),
    .bypass(bypass), .busy(busy), .activeSrc(activeSrc),
    .srcFaulty(srcFaulty), .srcRetired(srcRetired)
  );

  typedef struct { int kind; int sel; string req; } evt_t;  // kind 0 cfg, 1 ref, 2 bypass
  evt_t expQ[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_evt(input int kind, input int sel, input string req);
    evt_t e;
    e.kind = kind; e.sel = sel; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: every request edge and bypass entry is compared against the queue
  logic pCfg = 0, pRef = 0, pByp = 0;
  always @(negedge clk) begin
    if (rstN) begin
      int kind;
      int sel;
      kind = -1; sel = 0;
      if (cfgReq && !pCfg) begin kind = 0; sel = int'(cfgSel); end
      else if (refReq && !pRef) begin kind = 1; sel = int'(refSel); end
      else if (bypass && !pByp) begin kind = 2; end
      if (kind >= 0) begin
        if (expQ.size() == 0) begin
          chk("unexpected event", kind, -1);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          chk({e.req, " event kind"}, kind, e.kind);
          if (kind != 2) chk({e.req, " source"}, sel, e.sel);
        end
      end
    end
    pCfg = cfgReq; pRef = refReq; pByp = bypass;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pulse(input logic pass);
    @(negedge clk); checkValid = 1; checkPass = pass;
    @(negedge clk); checkValid = 0; checkPass = 0;
  endtask

  task automatic wait_sig(input int which);
    for (int i = 0; i < 200; i++) begin
      if ((which == 0 && cfgReq) || (which == 1 && refReq) || (which == 2 && bypass)) return;
      @(negedge clk);
    end
    chk("wait timeout", which, -1);
  endtask

  task automatic cfg_done();
    wait_sig(0); cyc(2);
    cfgDone = 1; @(negedge clk); cfgDone = 0;
  endtask

  task automatic ref_done(input logic ok);
    wait_sig(1); cyc(2);
    refDone = 1; refOk = ok; @(negedge clk); refDone = 0; refOk = 0;
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    @(negedge clk);
    chk("R1 bypass", bypass, 0);
    chk("R1 busy", busy, 0);
    chk("R1 requests", {cfgReq, refReq}, 0);
    chk("R1 active", activeSrc, 0);
    chk("R1 flags", {srcFaulty, srcRetired}, 0);

    // R11: passing check in idle does nothing
    check_pulse(1); cyc(2);
    chk("R11 idle pass busy", busy, 0);
    chk("R11 idle pass flags", srcFaulty, 0);

    // R2 R4 R5: fail from 0, retry from 1, pass, rewrite 0 ok
    expect_evt(0, 1, "R2");
    check_pulse(0);
    chk("R2 cfgReq next cycle", cfgReq, 1);
    check_pulse(0);  // R11: result during configure ignored
    chk("R11 during cfg", {cfgReq, refReq, bypass}, 3'b100);
    cfg_done();
    expect_evt(1, 0, "R4");
    check_pulse(1);
    chk("R4 active switched", activeSrc, 1);
    chk("R4 suspect flagged", srcFaulty, 3'b001);
    ref_done(1);
    chk("R5 flag cleared", srcFaulty, 0);
    chk("R5 idle", busy, 0);

    // R6: fail from 1, retry 2, rewrite of 1 fails twice -> retired
    expect_evt(0, 2, "R2");
    check_pulse(0);
    cfg_done();
    expect_evt(1, 1, "R6");
    expect_evt(1, 1, "R6 reissue");
    check_pulse(1);
    chk("R4 active 2", activeSrc, 2);
    ref_done(0);
    chk("R6 refReq gap", refReq, 0);
    @(negedge clk);
    chk("R6 refReq again", refReq, 1);
    ref_done(0);
    chk("R6 retired", srcRetired, 3'b010);
    chk("R6 still faulty", srcFaulty, 3'b010);
    chk("R6 idle", busy, 0);

    // R8 refresh timeout, R10 same-cycle fail with refDone, R2 skip, R8 cfg timeout
    expect_evt(0, 0, "R2");
    check_pulse(0);
    cfg_done();
    expect_evt(1, 2, "R4");
    expect_evt(1, 2, "R8 refresh reissue");
    check_pulse(1);
    wait_sig(1);
    cyc(TMO);
    chk("R8 refresh timed out", refReq, 0);
    @(negedge clk);
    chk("R8 refresh reissued", refReq, 1);
    expect_evt(0, 2, "R10 pending recovery skips retired");
    expect_evt(2, 0, "R8 cfg timeout");
    cyc(1);
    refDone = 1; refOk = 1; checkValid = 1; checkPass = 0;
    @(negedge clk);
    refDone = 0; refOk = 0; checkValid = 0;
    chk("R10 refreshed flag cleared", srcFaulty, 3'b010);
    @(negedge clk);
    chk("R10 recovery started", cfgReq, 1);
    cyc(TMO + 1);
    chk("R8 bypass after cfg timeout", bypass, 1);

    // R7: sticky bypass, checks ignored
    check_pulse(0); check_pulse(1); cyc(3);
    chk("R7 bypass held", bypass, 1);
    chk("R7 no request", {cfgReq, refReq}, 0);
    chk("R7 flags unchanged", srcFaulty, 3'b010);
    @(negedge clk); bypassClr = 1; @(negedge clk); bypassClr = 0;
    chk("R7 bypass cleared", bypass, 0);
    chk("R7 active kept", activeSrc, 0);

    // R3: retry check fails -> bypass
    expect_evt(0, 2, "R2");
    expect_evt(2, 0, "R3");
    check_pulse(0);
    cfg_done();
    check_pulse(0);
    chk("R3 bypass", bypass, 1);
    @(negedge clk); bypassClr = 1; @(negedge clk); bypassClr = 0;

    // R9: retire memory 0, then no spare left
    expect_evt(0, 2, "R2");
    check_pulse(0);
    cfg_done();
    expect_evt(1, 0, "R6");
    expect_evt(1, 0, "R6 reissue");
    check_pulse(1);
    ref_done(0);
    ref_done(0);
    chk("R6 two retired", srcRetired, 3'b011);
    expect_evt(2, 0, "R9");
    check_pulse(0);
    chk("R9 direct bypass", bypass, 1);
    cyc(3);
    chk("R9 queue drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule